// File: doc/BRIEF.md
# MII Receive Nibble Framer

This block sits between a line decoder and a media-independent receive interface. The decoder hands it one nibble per enabled clock, together with a flag that says whether the carrier is valid. The framer looks for the run of preamble nibbles (value 0x5) and the start-of-frame delimiter nibble (value 0xD). It then presents the frame as a 4-bit data bus plus a data-valid strobe.

A 2-bit mode input selects how much of the preamble reaches the output. The full preamble can be passed, all of it can be stripped, or only the last `KEEP_PRE` preamble nibbles in front of the delimiter can be kept. The delimiter nibble is always delivered, and it always comes ahead of the data nibbles. To keep preamble nibbles that were seen before the delimiter arrived, every nibble travels through a fixed delay line of `KEEP_PRE` stages, followed by an output register.

Two one-clock flags report failed attempts. The first marks a carrier that drops before any delimiter is seen. The second marks a nibble that is neither 0x5 nor 0xD while the block is hunting for the delimiter.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is held, and after it is released with no enabled nibble yet, `rx_dv`, `rxd`, `rx_err` and `false_start` are all 0.
- R2: The block advances only on clocks where `nib_en` is 1. On other clocks `rx_dv` and `rxd` hold their values.
- R3: A nibble taken on an enabled clock appears on `rxd` after the enabled clock that comes `KEEP_PRE` enabled clocks later (default 2), so the latency is `KEEP_PRE`+1 enabled edges.
- R4: With `mode` = 2'b00 or 2'b11, every preamble nibble (0x5) of an attempt is delivered with `rx_dv` = 1, followed by the delimiter (0xD) and the data.
- R5: With `mode` = 2'b01, no preamble nibble is delivered, so the first nibble delivered with `rx_dv` = 1 is 0xD.
- R6: With `mode` = 2'b10, only the last `KEEP_PRE` preamble nibbles in front of the delimiter are delivered. When the preamble is shorter than that, all of it is delivered.
- R7: A delimiter that arrives as the first nibble under carrier, with no preamble, starts a frame in every mode.
- R8: Data nibbles are passed unchanged and in arrival order. For each byte, bits 3:0 go out first and bits 7:4 go out on the next nibble.
- R9: When the carrier-valid input drops after data, `rx_dv` falls on the output update that follows the last data nibble.
- R10: If the carrier drops while hunting after one or more preamble nibbles, `false_start` pulses. In modes 2'b01 and 2'b10 `rx_dv` stays low for that attempt.
- R11: A nibble other than 0x5 or 0xD under carrier while hunting pulses `rx_err`. Nothing more is delivered until the carrier has dropped, and a new frame is accepted after that.
- R12: `rx_err` and `false_start` are high for exactly one clock, only after an enabled clock, and never together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| nib_en | input | 1 | Advance by one nibble on this clock |
| crs_ok | input | 1 | Carrier valid for the nibble on `nib_in` |
| nib_in | input | 4 | Nibble from the line decoder |
| mode | input | 2 | Preamble handling: 00 or 11 full, 01 strip, 10 keep last `KEEP_PRE` |
| rxd | output | 4 | Receive data nibble, 0 when `rx_dv` is low |
| rx_dv | output | 1 | Receive data valid |
| rx_err | output | 1 | One-clock pulse on a bad nibble while hunting |
| false_start | output | 1 | One-clock pulse when the carrier is lost before a delimiter |

## Verification
The assertions take for granted that `mode` is held steady from the first preamble nibble of an attempt until the attempt has drained out of the delay line. They also assume that `nib_in` only matters on clocks where `nib_en` is high.

The stimulus follows these rules. It changes `mode` only after at least `KEEP_PRE`+2 enabled idle nibbles with the carrier low. It drives arbitrary nibbles on disabled clocks while leaving the carrier unchanged across enable gaps. A behavioural queue model predicts every output on every clock, including during the gaps.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_SFD = 4'hD;

  localparam logic [1:0] MD_FULL  = 2'b00;
  localparam logic [1:0] MD_STRIP = 2'b01;
  localparam logic [1:0] MD_PART  = 2'b10;
  localparam logic [1:0] MD_FULL2 = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } hunt_st_e;

  // one nibble slot of the delay line
  typedef struct packed {
    logic       keep;  // to be delivered with rx_dv high
    logic       pre;   // preamble nibble of the current attempt
    logic [3:0] nib;
  } slot_t;

endpackage

// File: rtl/rxfr_sfd_hunt.sv
module rxfr_sfd_hunt
  import rxfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       crs_ok,
  input  logic [3:0] nib_in,
  input  logic [1:0] mode,
  output slot_t      slot_new,
  output logic       sfd_hit,
  output logic       rx_err,
  output logic       false_start
);

  hunt_st_e st_q, st_d;
  logic     err_d, fs_d;
  logic     full_md;

  assign full_md = (mode == MD_FULL) || (mode == MD_FULL2);

  always_comb begin
    st_d          = st_q;
    slot_new.keep = 1'b0;
    slot_new.pre  = 1'b0;
    slot_new.nib  = nib_in;
    sfd_hit       = 1'b0;
    err_d         = 1'b0;
    fs_d          = 1'b0;
    if (step) begin
      unique case (st_q)
        ST_IDLE, ST_HUNT: begin
          if (!crs_ok) begin
            fs_d = (st_q == ST_HUNT);
            st_d = ST_IDLE;
          end else if (nib_in == NIB_PRE) begin
            st_d          = ST_HUNT;
            slot_new.pre  = 1'b1;
            slot_new.keep = full_md;
          end else if (nib_in == NIB_SFD) begin
            st_d          = ST_DATA;
            slot_new.keep = 1'b1;
            sfd_hit       = 1'b1;
          end else begin
            err_d = 1'b1;
            st_d  = ST_DROP;
          end
        end
        ST_DATA: begin
          if (!crs_ok) st_d = ST_IDLE;
          else         slot_new.keep = 1'b1;
        end
        ST_DROP: begin
          if (!crs_ok) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rx_err      <= 1'b0;
      false_start <= 1'b0;
    end else begin
      if (step) st_q <= st_d;
      rx_err      <= err_d;
      false_start <= fs_d;
    end
  end

  // R12: pulses last one clock
  a_r12_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);
  a_r12_fs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> !false_start);
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_err && false_start));
  a_r12_flag_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err || false_start) |-> $past(step));
  // R11: after an error the block waits in drop until carrier falls
  a_r11_err_then_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (st_q == ST_DROP));

endmodule

// File: rtl/rxfr_delay_line.sv
module rxfr_delay_line
  import rxfr_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  slot_t      din,
  input  logic       mark,
  output logic       dout_keep,
  output logic [3:0] dout_nib
);

  slot_t            line_q [DEPTH];
  slot_t            line_d [DEPTH];
  logic [DEPTH-1:0] chain;

  // chain[i]: entry i belongs to the contiguous preamble run ending at the
  // newest entry, and the delimiter has just been seen in partial mode
  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      assign chain[0] = mark & line_q[0].pre;
      always_comb line_d[0] = din;
    end else begin : g_body
      assign chain[i] = chain[i-1] & line_q[i].pre;
      always_comb begin
        line_d[i]      = line_q[i-1];
        line_d[i].keep = line_q[i-1].keep | chain[i-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    line_q[i] <= '0;
      else if (step) line_q[i] <= line_d[i];
    end
  end

  assign dout_keep = line_q[DEPTH-1].keep | chain[DEPTH-1];
  assign dout_nib  = line_q[DEPTH-1].nib;

  // R6: only preamble entries get promoted by the mark
  a_r6_mark_only_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_keep && !line_q[DEPTH-1].keep) |-> (line_q[DEPTH-1].pre && dout_nib == NIB_PRE));

endmodule

// File: rtl/rxfr_out_stage.sv
module rxfr_out_stage
  import rxfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       keep,
  input  logic [3:0] nib,
  output logic [3:0] rxd,
  output logic       rx_dv
);

  logic [3:0] rxd_d;

  always_comb rxd_d = keep ? nib : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dv <= 1'b0;
      rxd   <= 4'h0;
    end else if (step) begin
      rx_dv <= keep;
      rxd   <= rxd_d;
    end
  end

  // R2: outputs hold on clocks without enable
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(rx_dv) && $stable(rxd)));
  // R4: a delivered stream opens with preamble or delimiter
  a_r4_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == NIB_PRE || rxd == NIB_SFD));

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import rxfr_pkg::*;
#(
  parameter int KEEP_PRE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_en,
  input  logic       crs_ok,
  input  logic [3:0] nib_in,
  input  logic [1:0] mode,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_err,
  output logic       false_start
);

  localparam int DEPTH = (KEEP_PRE < 1) ? 1 : KEEP_PRE;

  logic [1:0] rst_sync_q;
  logic       rst_i;
  slot_t      slot_new;
  logic       sfd_hit;
  logic       mark;
  logic       tail_keep;
  logic [3:0] tail_nib;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign mark = sfd_hit && (mode == MD_PART);

  rxfr_sfd_hunt u_hunt (
    .clk         (clk),
    .rst_n       (rst_i),
    .step        (nib_en),
    .crs_ok      (crs_ok),
    .nib_in      (nib_in),
    .mode        (mode),
    .slot_new    (slot_new),
    .sfd_hit     (sfd_hit),
    .rx_err      (rx_err),
    .false_start (false_start)
  );

  rxfr_delay_line #(.DEPTH(DEPTH)) u_dly (
    .clk       (clk),
    .rst_n     (rst_i),
    .step      (nib_en),
    .din       (slot_new),
    .mark      (mark),
    .dout_keep (tail_keep),
    .dout_nib  (tail_nib)
  );

  rxfr_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_i),
    .step  (nib_en),
    .keep  (tail_keep),
    .nib   (tail_nib),
    .rxd   (rxd),
    .rx_dv (rx_dv)
  );

  // R5: strip mode opens every delivered stream on the delimiter
  a_r5_strip_starts_sfd: assert property (@(posedge clk) disable iff (!rst_i)
    ($rose(rx_dv) && mode == MD_STRIP) |-> (rxd == NIB_SFD));
  // R1: idle bus carries zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_i)
    !rx_dv |-> (rxd == 4'h0));

endmodule

// File: tb/tb_mii_rx_framer.sv
module tb_mii_rx_framer;

  localparam int KEEP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       nib_en;
  logic       crs_ok;
  logic [3:0] nib_in;
  logic [1:0] mode;
  logic [3:0] rxd;
  logic       rx_dv;
  logic       rx_err;
  logic       false_start;

  always #5 clk = ~clk;

  mii_rx_framer #(.KEEP_PRE(KEEP)) dut (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .crs_ok(crs_ok),
    .nib_in(nib_in), .mode(mode), .rxd(rxd), .rx_dv(rx_dv),
    .rx_err(rx_err), .false_start(false_start)
  );

  typedef struct { bit keep; bit pre; logic [3:0] nib; } ent_t;

  int         checks = 0;
  int         errors = 0;
  ent_t       mq[$];
  int         mst = 0;  // 0 idle, 1 hunt, 2 data, 3 drop
  bit         exp_dv = 0, exp_err = 0, exp_fs = 0;
  logic [3:0] exp_rxd = 4'h0;
  bit         last_en = 0;
  string      cur_tag = "R3";
  int         dcount = 0, err_seen = 0, fs_seen = 0;
  logic [3:0] got[$];
  logic [7:0] sent[$];

  task automatic fail_line(string tg, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, expv);
  endtask

  task automatic check_eq(string tg, string what, int act, int expv);
    checks++;
    if (act != expv) fail_line(tg, what, act, expv);
  endtask

  task automatic model_step(bit c, logic [3:0] n);
    ent_t e, o;
    bit   sfd = 0;
    bit   full = (mode == 2'b00) || (mode == 2'b11);
    e.keep = 0; e.pre = 0; e.nib = n;
    exp_err = 0; exp_fs = 0;
    if (mst == 0 || mst == 1) begin
      if (!c) begin
        exp_fs = (mst == 1);
        mst = 0;
      end else if (n == 4'h5) begin
        mst = 1; e.pre = 1; e.keep = full;
      end else if (n == 4'hD) begin
        mst = 2; e.keep = 1; sfd = 1;
      end else begin
        exp_err = 1; mst = 3;
      end
    end else if (mst == 2) begin
      if (!c) mst = 0; else e.keep = 1;
    end else begin
      if (!c) mst = 0;
    end
    if (sfd && mode == 2'b10)
      for (int i = mq.size() - 1; i >= 0; i--) begin
        if (!mq[i].pre) break;
        mq[i].keep = 1;
      end
    o = mq.pop_front();
    exp_dv  = o.keep;
    exp_rxd = o.keep ? o.nib : 4'h0;
    mq.push_back(e);
  endtask

  task automatic step(bit en, bit c, logic [3:0] n);
    @(negedge clk);
    checks++;
    if (rx_dv !== exp_dv || rx_err !== exp_err || false_start !== exp_fs ||
        (exp_dv && rxd !== exp_rxd))
      fail_line(cur_tag, "dv/rxd/err/fs",
                {rx_dv, rxd, rx_err, false_start}, {exp_dv, exp_rxd, exp_err, exp_fs});
    if (last_en && rx_dv) begin dcount++; got.push_back(rxd); end
    if (rx_err) err_seen++;
    if (false_start) fs_seen++;
    nib_en = en; crs_ok = c; nib_in = n; last_en = en;
    if (en) model_step(c, n);
    else begin exp_err = 0; exp_fs = 0; end
  endtask

  task automatic step_g(int gap, bit c, logic [3:0] n);
    for (int g = 0; g < gap; g++) step(0, c, 4'h5 + 4'(g));
    step(1, c, n);
  endtask

  task automatic clr();
    dcount = 0; err_seen = 0; fs_seen = 0;
    got.delete(); sent.delete();
  endtask

  task automatic send_frame(int p, int nb, int seed, int gap, string tg);
    logic [7:0] b;
    clr();
    cur_tag = tg;
    for (int i = 0; i < p; i++) step_g(gap, 1, 4'h5);
    step_g(gap, 1, 4'hD);
    for (int i = 0; i < nb; i++) begin
      b = 8'((seed * 37 + i * 91 + 3) & 255);
      sent.push_back(b);
      step_g(gap, 1, b[3:0]);
      step_g(gap, 1, b[7:4]);
    end
    cur_tag = "R9";
    for (int i = 0; i < KEEP + 2; i++) step_g(gap, 0, 4'h0);
  endtask

  task automatic check_bytes(string tg);
    int base = got.size() - 2 * sent.size();
    for (int i = 0; i < sent.size(); i++)
      check_eq(tg, "byte lo-first", base < 0 ? -1 : {got[base+2*i+1], got[base+2*i]}, sent[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fail_line("R0", "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ent_t z;
    z.keep = 0; z.pre = 0; z.nib = 0;
    for (int i = 0; i < KEEP; i++) mq.push_back(z);
    rst_n = 0; nib_en = 0; crs_ok = 0; nib_in = 0; mode = 2'b00;
    repeat (3) @(negedge clk);
    check_eq("R1", "flags/dv in reset", {rx_dv, rx_err, false_start}, 0);
    check_eq("R1", "rxd in reset", rxd, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_eq("R1", "dv after release", rx_dv, 0);
    check_eq("R1", "rxd after release", rxd, 0);

    // R3 latency and R4 full mode
    send_frame(7, 3, 1, 0, "R3");
    check_eq("R4", "full count", dcount, 7 + 1 + 6);
    check_bytes("R8");
    mode = 2'b11;
    send_frame(3, 2, 2, 0, "R4");
    check_eq("R4", "mode11 count", dcount, 3 + 1 + 4);
    // R5 strip
    mode = 2'b01;
    send_frame(7, 2, 3, 0, "R5");
    check_eq("R5", "strip count", dcount, 1 + 4);
    check_eq("R5", "first nibble", got.size() > 0 ? got[0] : -1, 4'hD);
    check_bytes("R8");
    // R6 partial
    mode = 2'b10;
    send_frame(7, 2, 4, 0, "R6");
    check_eq("R6", "partial count", dcount, KEEP + 1 + 4);
    send_frame(1, 1, 5, 0, "R6");
    check_eq("R6", "short preamble count", dcount, 1 + 1 + 2);
    // R7 no preamble, each mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      send_frame(0, 2, 6 + m, 0, "R7");
      check_eq("R7", "no-preamble count", dcount, 1 + 4);
      check_bytes("R8");
    end
    // R2 enable gaps
    mode = 2'b10;
    send_frame(5, 2, 11, 2, "R2");
    check_eq("R2", "gapped count", dcount, KEEP + 1 + 4);
    check_bytes("R8");
    // R10 false start, strip mode and full mode
    mode = 2'b01;
    clr(); cur_tag = "R10";
    for (int i = 0; i < 4; i++) step_g(1, 1, 4'h5);
    for (int i = 0; i < KEEP + 2; i++) step_g(1, 0, 4'h0);
    check_eq("R10", "strip false start dv", dcount, 0);
    check_eq("R12", "fs pulses", fs_seen, 1);
    mode = 2'b00;
    clr(); cur_tag = "R10";
    for (int i = 0; i < 4; i++) step(1, 1, 4'h5);
    for (int i = 0; i < KEEP + 2; i++) step(1, 0, 4'h0);
    check_eq("R10", "full false start count", dcount, 4);
    check_eq("R10", "fs pulses", fs_seen, 1);
    // R11 bad nibble while hunting, then a good frame
    mode = 2'b10;
    clr(); cur_tag = "R11";
    for (int i = 0; i < 3; i++) step(1, 1, 4'h5);
    step(1, 1, 4'h7);
    step(1, 1, 4'h5); step(1, 1, 4'h5); step(1, 1, 4'hD);
    step(1, 1, 4'h3); step(1, 1, 4'h4);
    for (int i = 0; i < KEEP + 2; i++) step(1, 0, 4'h0);
    check_eq("R11", "dropped count", dcount, 0);
    check_eq("R11", "err pulses", err_seen, 1);
    check_eq("R12", "no fs on error", fs_seen, 0);
    send_frame(4, 1, 13, 1, "R11");
    check_eq("R11", "frame after drop", dcount, KEEP + 1 + 2);
    step(0, 0, 4'h0);
    step(0, 0, 4'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule